// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of its interrupt lines, if any, is presented to the processor. Each cycle it takes a pending vector and a mask vector from the surrounding controller. It ranks the unmasked pending lines against a rotatable priority base. It raises its request only when the best candidate outranks everything already being serviced. The block keeps the in-service vector and the priority base itself. Acknowledge, end-of-interrupt and rotation commands update that state on the clock edge.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready pair and no back-pressure. The acknowledge strobe and every command are taken in the cycle in which they are presented. The request, winner index and spurious flag are combinational functions of the registered state and the current inputs, so they are recomputed in every cycle. The cascade line index and whether the instance is the primary one are parameters.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset the in-service vector is empty and the priority base is 0. With nothing pending, irq_o is 0, spurious_o is 1 and win_idx_o is N_LINES-1.
- R2: The priority of line i is (i - base) mod N_LINES, and 0 is the highest. win_idx_o names the highest-priority line that is both pending and unmasked.
- R3: A masked line never wins. When no unmasked line is pending, irq_o is 0.
- R4: irq_o is 1 only when the winning priority is strictly higher than the highest priority in the in-service vector. A line already in service does not re-raise the request.
- R5: When sfnm_i is 1 on the primary instance, the in-service bit of the cascade line (CASC_LINE, default 2) is left out of that comparison.
- R6: An ack_i while irq_o is 1 and auto_eoi_i is 0 sets the in-service bit of win_idx_o.
- R7: An ack_i while irq_o is 1 and auto_eoi_i is 1 leaves no in-service bit set for the winner. If rot_aeoi_i is also 1, the base becomes (winner + 1) mod N_LINES.
- R8: An ack_i while irq_o is 0 reports spurious_o=1 with win_idx_o = N_LINES-1 and changes no state.
- R9: cmd_i=1 (non-specific EOI) clears the highest-priority in-service bit. cmd_i=2 does the same and also sets the base to that line + 1. Both have no effect when nothing is in service.
- R10: cmd_i=3 (specific EOI) clears in-service bit cmd_idx_i. cmd_i=4 does the same and also sets the base to cmd_idx_i + 1.
- R11: cmd_i=5 sets the base to cmd_idx_i + 1 and leaves the in-service vector unchanged. cmd_i values 0, 6 and 7 do nothing.
- R12: When a command and an acknowledge arrive in the same cycle, the command's clear is applied first and the acknowledge's set second. A base change made by auto-EOI rotation overrides the base change made by the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | N_LINES | Pending request vector |
| mask_i | input | N_LINES | Mask vector, 1 blocks the line |
| ack_i | input | 1 | Processor acknowledge strobe |
| cmd_i | input | 3 | Command code (see R9 to R11) |
| cmd_idx_i | input | IDX_W | Line index used by specific EOI and base-set commands |
| auto_eoi_i | input | 1 | Automatic end of interrupt at acknowledge |
| rot_aeoi_i | input | 1 | Rotate the base on automatic EOI |
| sfnm_i | input | 1 | Special fully nested mode |
| irq_o | output | 1 | Interrupt request to the processor |
| win_idx_o | output | IDX_W | Winning line, or N_LINES-1 when spurious |
| spurious_o | output | 1 | No valid winner this cycle |

## Verification
Several properties are checked on every cycle by the assertions:
- a winner is always an unmasked pending line that is not already counted as in service;
- a taken acknowledge without auto-EOI marks its line;
- an auto-EOI rotation moves the base just past the winner;
- a non-specific EOI clears its target;
- a base-set command leaves the in-service vector alone.

Other behaviours show only over sequences, so the bench's scenarios cover them. These are the arithmetic of the rotated priority across every base and pending pattern, and strict nesting against in-service lines. They also include the cascade exclusion, spurious acknowledges leaving state intact, and command and acknowledge ordering within one cycle.

// File: rtl/prr_pkg.sv
package prr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_EOI_NS     = 3'd1,
    CMD_EOI_NS_ROT = 3'd2,
    CMD_EOI_SP     = 3'd3,
    CMD_EOI_SP_ROT = 3'd4,
    CMD_SET_BASE   = 3'd5
  } prr_cmd_e;
endpackage

// File: rtl/prr_scan.sv
// Rotated priority scan: finds the first set bit starting at base, wrapping.
module prr_scan #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] base,
  output logic         found,
  output logic [W-1:0] prio,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    prio  = '0;
    idx   = '0;
    // descending so the lowest offset is the last to assign
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[W'(base + W'(k))]) begin
        found = 1'b1;
        prio  = W'(k);
        idx   = W'(base + W'(k));
      end
    end
  end

  always_comb begin
    if (found) a_r2_found_bit_set: assert (vec[idx]);
  end
endmodule

// File: rtl/prr_isr.sv
// In-service vector: clear applied before set.
module prr_isr #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_idx,
  input  logic         set_en,
  input  logic [W-1:0] set_idx,
  output logic [N-1:0] isr
);
  logic [N-1:0] isr_nxt;

  always_comb begin
    isr_nxt = isr;
    if (clr_en) isr_nxt[clr_idx] = 1'b0;
    if (set_en) isr_nxt[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_nxt;
  end
endmodule

// File: rtl/prr_base.sv
// Priority base register with two load sources; source b wins.
module prr_base #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_a,
  input  logic [W-1:0] val_a,
  input  logic         ld_b,
  input  logic [W-1:0] val_b,
  output logic [W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)    base <= '0;
    else if (ld_b) base <= val_b;
    else if (ld_a) base <= val_a;
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import prr_pkg::*;
#(
  parameter int N_LINES    = 8,
  parameter int CASC_LINE  = 2,
  parameter bit IS_PRIMARY = 1'b1,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               ack_i,
  input  logic [2:0]         cmd_i,
  input  logic [IDX_W-1:0]   cmd_idx_i,
  input  logic               auto_eoi_i,
  input  logic               rot_aeoi_i,
  input  logic               sfnm_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic               spurious_o
);
  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASC_LINE;

  logic [N_LINES-1:0] isr, cand, isr_cur;
  logic [IDX_W-1:0]   base;
  logic               req_found, cur_found, top_found;
  logic [IDX_W-1:0]   req_prio, req_idx, cur_prio, cur_idx, top_prio, top_idx;
  prr_cmd_e           cmd;
  logic               is_ns, is_sp, rot_cmd, take;
  logic               clr_en, base_a_en, set_en, base_b_en;
  logic [IDX_W-1:0]   tgt_idx;

  assign cmd     = prr_cmd_e'(cmd_i);
  assign cand    = pend_i & ~mask_i;
  assign isr_cur = (IS_PRIMARY && sfnm_i) ? (isr & ~CASC_BIT) : isr;

  prr_scan #(.N(N_LINES)) u_req (.vec(cand),    .base(base), .found(req_found),
                                 .prio(req_prio), .idx(req_idx));
  prr_scan #(.N(N_LINES)) u_cur (.vec(isr_cur), .base(base), .found(cur_found),
                                 .prio(cur_prio), .idx(cur_idx));
  prr_scan #(.N(N_LINES)) u_top (.vec(isr),     .base(base), .found(top_found),
                                 .prio(top_prio), .idx(top_idx));

  assign irq_o      = req_found && (!cur_found || (req_prio < cur_prio));
  assign win_idx_o  = irq_o ? req_idx : IDX_W'(N_LINES - 1);
  assign spurious_o = ~irq_o;
  assign take       = ack_i & irq_o;

  always_comb begin
    is_ns   = (cmd == CMD_EOI_NS)     || (cmd == CMD_EOI_NS_ROT);
    is_sp   = (cmd == CMD_EOI_SP)     || (cmd == CMD_EOI_SP_ROT);
    rot_cmd = (cmd == CMD_EOI_NS_ROT) || (cmd == CMD_EOI_SP_ROT);
    tgt_idx = is_ns ? top_idx : cmd_idx_i;
    clr_en  = (is_ns && top_found) || is_sp;
    base_a_en = (rot_cmd && (is_sp || top_found)) || (cmd == CMD_SET_BASE);
    set_en    = take && !auto_eoi_i;
    base_b_en = take && auto_eoi_i && rot_aeoi_i;
  end

  prr_isr #(.N(N_LINES)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .clr_en(clr_en), .clr_idx(tgt_idx),
    .set_en(set_en), .set_idx(win_idx_o),
    .isr(isr)
  );

  prr_base #(.N(N_LINES)) u_base (
    .clk(clk), .rst_n(rst_n),
    .ld_a(base_a_en), .val_a(IDX_W'(tgt_idx + IDX_W'(1))),
    .ld_b(base_b_en), .val_b(IDX_W'(win_idx_o + IDX_W'(1))),
    .base(base)
  );

  // R3: a request always names an unmasked pending line
  a_r3_winner_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cand[win_idx_o]);
  // R4: the presented line is not already counted as in service
  a_r4_winner_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !isr_cur[win_idx_o]);
  // R6
  a_r6_ack_marks_line: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !auto_eoi_i) |=> isr[$past(win_idx_o)]);
  // R7
  a_r7_aeoi_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && auto_eoi_i && rot_aeoi_i) |=>
      base == IDX_W'($past(win_idx_o) + IDX_W'(1)));
  // R9
  a_r9_ns_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_EOI_NS && !ack_i && top_found) |=> !isr[$past(top_idx)]);
  // R11
  a_r11_setbase_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SET_BASE && !ack_i) |=> isr == $past(isr));
endmodule

// File: tb/tb_rot_prio_resolver.sv
module tb_rot_prio_resolver;
  localparam int CLK_P = 10;
  localparam logic [2:0] C_NOP = 3'd0, C_NS = 3'd1, C_NSR = 3'd2,
                         C_SP = 3'd3, C_SPR = 3'd4, C_SB = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pend = '0, mask = '0;
  logic ack = 1'b0, ae = 1'b0, ra = 1'b0, sf = 1'b0;
  logic [2:0] cmd = '0, cidx = '0;
  logic irq, spur;
  logic [2:0] widx;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_isr = '0;
  int m_base = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  rot_prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .ack_i(ack),
    .cmd_i(cmd), .cmd_idx_i(cidx), .auto_eoi_i(ae), .rot_aeoi_i(ra),
    .sfnm_i(sf), .irq_o(irq), .win_idx_o(widx), .spurious_o(spur)
  );

  function automatic int bestp(input logic [7:0] v, input int b);
    for (int k = 0; k < 8; k++) if (v[(k + b) % 8]) return k;
    return 8;
  endfunction

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  // one cycle: drive, check outputs against the model, then advance the model
  task automatic cyc(input logic [7:0] p, input logic [7:0] m, input logic [2:0] c,
                     input logic [2:0] ci, input logic a, input logic e,
                     input logic r, input logic s, input string tag);
    int rp, cp, tp, widx_e, tgt;
    logic irq_e;
    logic [7:0] nisr;
    int nbase;
    @(negedge clk);
    pend = p; mask = m; cmd = c; cidx = ci; ack = a; ae = e; ra = r; sf = s;
    #(CLK_P/4);
    rp = bestp(p & ~m, m_base);
    cp = bestp(s ? (m_isr & ~8'h04) : m_isr, m_base);
    irq_e  = (rp < 8) && (rp < cp);
    widx_e = irq_e ? (rp + m_base) % 8 : 7;
    n_chk++;
    if (irq !== irq_e || widx !== 3'(widx_e) || spur !== !irq_e) begin
      n_fail++;
      $display("FAIL %s: irq/idx/spur act %b/%0d/%b exp %b/%0d/%b",
               tag, irq, widx, spur, irq_e, widx_e, !irq_e);
    end
    nisr = m_isr; nbase = m_base;
    tp = bestp(m_isr, m_base);
    tgt = (c == C_NS || c == C_NSR) ? (tp + m_base) % 8 : int'(ci);
    if ((c == C_NS || c == C_NSR) && tp < 8) nisr[tgt] = 1'b0;
    if (c == C_SP || c == C_SPR) nisr[tgt] = 1'b0;
    if ((c == C_NSR && tp < 8) || c == C_SPR || c == C_SB) nbase = (tgt + 1) % 8;
    if (a && irq_e) begin
      if (!e) nisr[widx_e] = 1'b1;
      else if (r) nbase = (widx_e + 1) % 8;
    end
    @(posedge clk);
    m_isr = nisr; m_base = nbase;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act running exp finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    cyc(8'h00, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R1");
    cyc(8'h80, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R1");
    // R2 / R11: every base, every pending pattern
    for (int b = 0; b < 8; b++) begin
      cyc(8'h00, 8'h00, C_SB, 3'(b + 7), 0, 0, 0, 0, "R11");
      for (int v = 0; v < 256; v++)
        cyc(8'(v), 8'h00, C_NOP, 0, 0, 0, 0, 0, "R2");
    end
    // R3: all pending, every mask
    for (int v = 0; v < 256; v++)
      cyc(8'hFF, 8'(v), C_NOP, 0, 0, 0, 0, 0, "R3");
    // R6 / R4: nesting with base 0
    cyc(8'h00, 8'h00, C_SB, 7, 0, 0, 0, 0, "R11");
    cyc(8'h08, 8'h00, C_NOP, 0, 1, 0, 0, 0, "R6");
    cyc(8'h20, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R4");
    cyc(8'h08, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R4");
    cyc(8'h02, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R4");
    // R8: spurious acknowledge leaves state alone
    cyc(8'h00, 8'h00, C_NOP, 0, 1, 0, 0, 0, "R8");
    cyc(8'h20, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R8");
    // R9: non-specific EOI
    cyc(8'h00, 8'h00, C_NS, 0, 0, 0, 0, 0, "R9");
    cyc(8'h20, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R9");
    cyc(8'h00, 8'h00, C_NS, 0, 0, 0, 0, 0, "R9");
    // R5: cascade line exclusion
    cyc(8'h04, 8'h00, C_NOP, 0, 1, 0, 0, 0, "R5");
    cyc(8'h08, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R5");
    cyc(8'h08, 8'h00, C_NOP, 0, 0, 0, 0, 1, "R5");
    cyc(8'h04, 8'h00, C_NOP, 0, 0, 0, 0, 1, "R5");
    // R10: specific EOI of line 2
    cyc(8'h00, 8'h00, C_SP, 2, 0, 0, 0, 0, "R10");
    cyc(8'h08, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R10");
    // R7: auto EOI with rotation
    cyc(8'h10, 8'h00, C_NOP, 0, 1, 1, 1, 0, "R7");
    cyc(8'h30, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R7");
    cyc(8'h11, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R7");
    cyc(8'h40, 8'h00, C_NOP, 0, 1, 1, 0, 0, "R7");
    cyc(8'h40, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R7");
    // R10 rotating, R9 rotating
    cyc(8'h01, 8'h00, C_NOP, 0, 1, 0, 0, 0, "R6");
    cyc(8'h00, 8'h00, C_SPR, 3, 0, 0, 0, 0, "R10");
    cyc(8'h18, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R10");
    cyc(8'h00, 8'h00, C_NSR, 0, 0, 0, 0, 0, "R9");
    cyc(8'h03, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R9");
    // R12: command and acknowledge together
    cyc(8'h02, 8'h00, C_NOP, 0, 1, 0, 0, 0, "R12");
    cyc(8'h02, 8'h00, C_SP, 1, 1, 0, 0, 0, "R12");
    cyc(8'h02, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R12");
    cyc(8'h04, 8'h00, C_SB, 6, 1, 1, 1, 0, "R12");
    cyc(8'hFF, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R12");
    // R11: unused codes do nothing
    cyc(8'h00, 8'h00, 3'd6, 4, 0, 0, 0, 0, "R11");
    cyc(8'h00, 8'h00, 3'd7, 4, 0, 0, 0, 0, "R11");
    cyc(8'hFF, 8'h00, C_NOP, 0, 0, 0, 0, 0, "R11");
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      lfsr = rnd(lfsr);
      cyc(lfsr[7:0], lfsr[15:8] & lfsr[23:16], (lfsr[26:24] > 3'd5) ? C_NOP : lfsr[26:24],
          lfsr[29:27], lfsr[30], lfsr[31], lfsr[3], lfsr[12], "R4");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule